// File: doc/BRIEF.md
# Watchdog Timer with Guarded Protection-Mode Register

This block is a watchdog down-counter with a small register interface. The counter is loaded with a fixed start value. Each enabled tick counts it down, and a refresh strobe reloads it. If a tick arrives while the count is zero, the counter has underflowed. It then raises a one-cycle interrupt pulse, reloads, and sets a sticky detection flag. Software can read that flag and can clear it by writing 0, but a write of 1 cannot set it.

A second register holds one protection-mode bit, which a neighbouring clock-source block uses. Its reset value follows a nonvolatile option input: option 0 gives mode enabled, and option 1 gives mode disabled. Software can turn the mode on only through a guarded pair of writes, first 0 and then 1. Software can never turn it off. Once the counter has taken its first tick, the bit is frozen until the next reset.

Top module: `wdg_guard`

## Requirements
- R1: While `rst_i` is high, the protection register takes 0x80 if `opt_init_i` is 0 and 0x00 if it is 1. The flag register resets to 0 and `irq_o` resets to 0.
- R2: A refresh reloads the counter with START_VAL, and every tick without refresh decrements it. A tick at count 0 makes `irq_o` high for exactly the following cycle and reloads the counter. After a refresh, START_VAL+1 ticks therefore produce the pulse.
- R3: The detection flag is bit 3 of the register at FLAG_ADDR (default 0x37D). It reads 1 from the cycle after the `irq_o` pulse onward.
- R4: A write to FLAG_ADDR with bit 3 equal to 0 clears the flag. A write with bit 3 equal to 1 leaves it unchanged. An underflow in the same cycle wins over the clear.
- R5: The protection register at PROT_ADDR (0x37C) holds the mode in bit 7. Bits 6 to 0 always read 0, whatever is written to them.
- R6: A write to PROT_ADDR with bit 7 = 0 arms the sequence. The next write with bit 7 = 1 then sets the mode bit.
- R7: A write of bit 7 = 1 while the sequence is not armed is ignored. Any write to another address disarms the sequence.
- R8: Once the mode bit is 1, no write clears it. Only reset can clear it.
- R9: From the first tick after reset until the next reset, the mode bit cannot change.
- R10: Reads from any address other than the two mapped ones return 0.
- R11: `prot_mode_o` always equals bit 7 of the protection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opt_init_i | input | 1 | Nonvolatile option bit, sampled while reset is high |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| tick_i | input | 1 | Count-enable tick |
| refresh_i | input | 1 | Refresh strobe that reloads the counter |
| irq_o | output | 1 | Underflow interrupt pulse |
| prot_mode_o | output | 1 | Protection mode enabled |

## Verification
The bench builds the block with CNT_W = 4 and START_VAL = 5. This lets an underflow, its reload and the refresh path complete within a handful of ticks, so the exact tick on which the pulse appears can be checked. The register addresses and the flag position keep their defaults, so the bench writes to the real offsets. With both option levels used across resets, both reset values of the mode bit are covered. The test of the lock after the first tick is also reachable.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Decoded register-bus access, as seen by the protection register
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ARM   = 2'd1,
        OP_SET   = 2'd2,
        OP_OTHER = 2'd3
    } bus_op_t;

    typedef struct packed {
        logic mode;
        logic armed;
    } prot_state_t;

endpackage

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned START_VAL = 4095
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic refresh_i,
    output logic uf_o,
    output logic started_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(START_VAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             uf;
        logic             started;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.uf = 1'b0;
        if (tick_i) begin
            st_d.started = 1'b1;
        end
        if (refresh_i) begin
            st_d.cnt = RELOAD;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = RELOAD;
                st_d.uf  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (rst_i) begin
            st_d.cnt     = RELOAD;
            st_d.uf      = 1'b0;
            st_d.started = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign uf_o      = st_q.uf;
    assign started_o = st_q.started;

endmodule

// File: rtl/wdg_protect.sv
module wdg_protect
    import wdg_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    opt_init_i,
    input  bus_op_t op_i,
    input  logic    lock_i,
    output logic    mode_o
);
    prot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_ARM: st_d.armed = 1'b1;
            OP_SET: begin
                if (st_q.armed && !lock_i) begin
                    st_d.mode = 1'b1;
                end
                st_d.armed = 1'b0;
            end
            OP_OTHER: st_d.armed = 1'b0;
            default: ;
        endcase
        if (rst_i) begin
            st_d.mode  = ~opt_init_i;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned START_VAL = 4095,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 12'h37C,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h37D,
    parameter int unsigned FLAG_BIT = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              opt_init_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tick_i,
    input  logic              refresh_i,
    output logic              irq_o,
    output logic              prot_mode_o
);
    localparam int unsigned MODE_BIT = DATA_W - 1;

    logic    uf;
    logic    started;
    logic    mode;
    bus_op_t op;
    logic    flag_d, flag_q;

    wdg_counter #(
        .CNT_W     (CNT_W),
        .START_VAL (START_VAL)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .refresh_i (refresh_i),
        .uf_o      (uf),
        .started_o (started)
    );

    always_comb begin
        op = OP_NONE;
        if (we_i) begin
            if (addr_i == PROT_ADDR) begin
                op = wdata_i[MODE_BIT] ? OP_SET : OP_ARM;
            end else begin
                op = OP_OTHER;
            end
        end
    end

    wdg_protect u_prot (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .opt_init_i (opt_init_i),
        .op_i       (op),
        .lock_i     (started),
        .mode_o     (mode)
    );

    always_comb begin
        flag_d = flag_q;
        if (we_i && addr_i == FLAG_ADDR && !wdata_i[FLAG_BIT]) begin
            flag_d = 1'b0;
        end
        if (uf) begin
            flag_d = 1'b1;
        end
        if (rst_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        flag_q <= flag_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == FLAG_ADDR) begin
            rdata_o[FLAG_BIT] = flag_q;
        end else if (addr_i == PROT_ADDR) begin
            rdata_o[MODE_BIT] = mode;
        end
    end

    assign irq_o       = uf;
    assign prot_mode_o = mode;

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 12'h37C
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              tick_i,
    input logic              refresh_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wdata_msb,
    input logic              irq_o,
    input logic              mode,
    input logic              flag,
    input logic              started
);
    // R2: a pulse needs a tick without refresh in the cycle before
    a_r2_irq_from_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> $past(tick_i && !refresh_i));

    // R3: an underflow pulse sets the flag on the next cycle
    a_r3_flag_follows_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> flag);

    // R8: the mode bit is never cleared by software
    a_r8_mode_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        mode |=> mode);

    // R6: the mode bit only rises after a write of 1 to the protection register
    a_r6_rise_needs_write: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(mode) |-> $past(we_i && addr_i == PROT_ADDR && wdata_msb));

    // R9: the mode bit is frozen once counting has begun
    a_r9_frozen_after_start: assert property (@(posedge clk_i) disable iff (rst_i)
        started |=> $stable(mode));

endmodule

bind wdg_guard wdg_guard_chk #(
    .ADDR_W    (ADDR_W),
    .PROT_ADDR (PROT_ADDR)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick_i),
    .refresh_i (refresh_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_msb (wdata_i[DATA_W-1]),
    .irq_o     (irq_o),
    .mode      (mode),
    .flag      (flag_q),
    .started   (started)
);

// File: tb/wdg_guard_test.sv
module wdg_guard_test;
    localparam logic [11:0] PROT = 12'h37C;
    localparam logic [11:0] FLAG = 12'h37D;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        opt_init_i = 1'b1;
    logic [11:0] addr_i = '0;
    logic        we_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        tick_i = 1'b0;
    logic        refresh_i = 1'b0;
    logic        irq_o;
    logic        prot_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int irq_seen = 0;

    always #2.5 clk = ~clk;

    wdg_guard #(.CNT_W(4), .START_VAL(5)) uut (
        .clk_i(clk), .rst_i(rst_i), .opt_init_i(opt_init_i),
        .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .tick_i(tick_i), .refresh_i(refresh_i), .irq_o(irq_o),
        .prot_mode_o(prot_mode_o)
    );

    always @(negedge clk) if (irq_o) irq_seen++;

    // Protection sequence vectors, option = 1 and no tick yet: {addr, wdata, expected prot read}
    // R7 unarmed set ignored, other write disarms; R6 arm then set; R5 low bits 0; R8 no clear
    localparam logic [27:0] VEC [8] = '{
        {PROT, 8'h80, 8'h00},   // R7
        {PROT, 8'h00, 8'h00},   // arm
        {FLAG, 8'hFF, 8'h00},   // other address disarms
        {PROT, 8'h80, 8'h00},   // R7
        {PROT, 8'h00, 8'h00},   // arm
        {PROT, 8'hFF, 8'h80},   // R6, R5
        {PROT, 8'h00, 8'h80},   // R8
        {PROT, 8'h7F, 8'h80}    // R8, R5
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [11:0] a, input logic [7:0] d,
                        input logic tk, input logic rf);
        @(negedge clk);
        we_i = we; addr_i = a; wdata_i = d; tick_i = tk; refresh_i = rf;
        @(negedge clk);
        we_i = 1'b0; tick_i = 1'b0; refresh_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        we_i = 1'b0; addr_i = a;
        #1 chk(rdata_o, exp, tag);
    endtask

    task automatic do_reset(input logic opt);
        @(negedge clk);
        rst_i = 1'b1; opt_init_i = opt;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
        opt_init_i = ~opt;  // option is only sampled during reset
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        rd(PROT, 8'h00, "R1 prot reset, option 1");
        rd(FLAG, 8'h00, "R1 flag reset");
        chk({7'd0, irq_o}, 8'h00, "R1 irq reset");
        rd(12'h000, 8'h00, "R10 unmapped read");
        rd(12'h37E, 8'h00, "R10 unmapped read");

        for (int i = 0; i < 8; i++) begin
            step(1'b1, VEC[i][27:16], VEC[i][15:8], 1'b0, 1'b0);
            rd(PROT, VEC[i][7:0], "R5-8 vector");
            chk({7'd0, prot_mode_o}, {7'd0, VEC[i][7]}, "R11 mode port");
        end
        rd(FLAG, 8'h00, "R4 write of 1 does not set flag");

        // R2: START_VAL+1 ticks after refresh give one pulse
        do_reset(1'b1);
        step(1'b0, FLAG, 8'h00, 1'b0, 1'b1);
        irq_seen = 0;
        for (int i = 0; i < 5; i++) step(1'b0, FLAG, 8'h00, 1'b1, 1'b0);
        chk(8'(irq_seen), 8'd0, "R2 no pulse before underflow");
        step(1'b0, FLAG, 8'h00, 1'b1, 1'b0);
        chk({7'd0, irq_o}, 8'h01, "R2 pulse on underflow tick");
        rd(FLAG, 8'h08, "R3 flag set after pulse");
        chk({7'd0, irq_o}, 8'h00, "R2 pulse lasts one cycle");

        // R4: write 1 keeps, write 0 clears
        step(1'b1, FLAG, 8'h08, 1'b0, 1'b0);
        rd(FLAG, 8'h08, "R4 write 1 keeps flag");
        step(1'b1, FLAG, 8'hF7, 1'b0, 1'b0);
        rd(FLAG, 8'h00, "R4 write 0 clears flag");

        // R2: reload after underflow, refresh in the middle restarts count
        irq_seen = 0;
        for (int i = 0; i < 4; i++) step(1'b0, FLAG, 8'h00, 1'b1, 1'b0);
        step(1'b0, FLAG, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, FLAG, 8'h00, 1'b1, 1'b0);
        chk(8'(irq_seen), 8'd0, "R2 refresh prevents underflow");
        step(1'b0, FLAG, 8'h00, 1'b1, 1'b0);
        chk({7'd0, irq_o}, 8'h01, "R2 pulse after refresh window");

        // R9: sequence after counting started is ignored
        step(1'b1, PROT, 8'h00, 1'b0, 1'b0);
        step(1'b1, PROT, 8'h80, 1'b0, 1'b0);
        rd(PROT, 8'h00, "R9 mode locked after start");
        chk({7'd0, prot_mode_o}, 8'h00, "R9 mode port locked");

        // R1 with option 0, then R8 under write 0 and R9 stays set after ticks
        do_reset(1'b0);
        rd(PROT, 8'h80, "R1 prot reset, option 0");
        chk({7'd0, prot_mode_o}, 8'h01, "R11 mode port after reset");
        step(1'b1, PROT, 8'h00, 1'b0, 1'b0);
        rd(PROT, 8'h80, "R8 write 0 does not clear");
        step(1'b0, FLAG, 8'h00, 1'b1, 1'b0);
        rd(PROT, 8'h80, "R9 mode kept after start");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule